// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This unit sits between a processor's register-read stage and a byte-addressed data memory that is 32 bits wide. For each request it adds a sign-extended 16-bit displacement to a base register value to form a byte address. It then issues a word address to the memory. For stores it also issues per-byte write enables and the write data, with the byte placed in the lane its address selects. Four operations are handled: word load, word store, byte load and byte store, chosen by a 6-bit opcode.

The memory is assumed to return read data one clock after the read strobe. The unit remembers the size and byte position of each load, so it can return the full word or the selected byte, sign-extended, in that following cycle. A word access whose address is not a multiple of four is refused: the unit raises an error flag and drives no memory strobe. Lanes are big-endian. Byte offset 0 within a word occupies bits 31:24, and byte offset 3 occupies bits 7:0.

Top module: `ls_lane_unit`

## Requirements
- R1: The byte address is `baseReg` plus `offset` sign-extended to 32 bits. `memWordAddr` carries bits 31:2 of that address whenever `memRead` or `memWrite` is high.
- R2: Opcode 35 selects a word load, 43 a word store, 32 a byte load and 40 a byte store. Any other opcode, or `reqValid` low, leaves `memRead`, `memWrite`, `memByteEn` and `misaligned` all at 0.
- R3: An aligned word store raises `memWrite`, sets all four bits of `memByteEn` and drives `storeData` unchanged on `memWdata`.
- R4: A byte store raises `memWrite` with exactly one `memByteEn` bit set. Byte offset k enables bit 3-k, which covers lane bits [31-8k:24-8k]. The low byte of `storeData` is copied into all four lanes of `memWdata`.
- R5: An aligned word load raises `memRead` in the request cycle. In the next cycle `loadValid` is 1 and `loadData` equals `memRdata`.
- R6: A byte load returns, one cycle after the request, the byte at its big-endian lane of `memRdata`, sign-extended from bit 7 to 32 bits.
- R7: A word access with address bits 1:0 not both zero raises `misaligned` in the request cycle. It drives `memRead`, `memWrite` and `memByteEn` to 0, and `loadValid` stays 0 in the next cycle.
- R8: Byte accesses are never flagged as misaligned, whatever their low address bits.
- R9: While `rstN` is low, `loadValid` is 0. After reset, `loadValid` rises only in the cycle after a `memRead`.
- R10: A load result returning in the same cycle as a new request is not disturbed by that request, and the new request's strobes are not disturbed by the returning load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A memory request is present this cycle |
| opcode | input | 6 | Operation code (35, 43, 32, 40) |
| baseReg | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| storeData | input | 32 | Register value to be stored |
| memWordAddr | output | 30 | Word address to memory |
| memByteEn | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| memWrite | output | 1 | Write strobe |
| memRead | output | 1 | Read strobe |
| memWdata | output | 32 | Lane-steered write data |
| memRdata | input | 32 | Word read from memory, valid the cycle after memRead |
| loadValid | output | 1 | loadData is valid this cycle |
| loadData | output | 32 | Word or sign-extended byte for the register file |
| misaligned | output | 1 | Word access refused for bad alignment |

## Verification
Two of this unit's functions can be active in the same cycle: the return of a load's result, and the decoding and issue of the next request. The bench sets this up by issuing a word load and then a byte store to a different word in the very next cycle. A byte load follows, and it must read back the byte just written. In the overlap cycle the bench checks both the returned load word and the store's enables, data and address against values worked out by hand, and it checks the following byte load's sign-extended result.

// File: rtl/ls_lane_pkg.sv
package ls_lane_pkg;
  localparam logic [5:0] OPC_LOAD_BYTE  = 6'd32;
  localparam logic [5:0] OPC_LOAD_WORD  = 6'd35;
  localparam logic [5:0] OPC_STORE_BYTE = 6'd40;
  localparam logic [5:0] OPC_STORE_WORD = 6'd43;

  // strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic wordSize;
    logic addrErr;
  } lsStrobe_t;
endpackage

// File: rtl/ls_lane_ctrl.sv
module ls_lane_ctrl
  import ls_lane_pkg::*;
#(
  parameter int LANE_BITS = 2
) (
  input  logic                 reqValid,
  input  logic [5:0]           opcode,
  input  logic [LANE_BITS-1:0] addrLow,
  output lsStrobe_t            strobe
);
  logic isLoad, isStore, isWord, known, aligned, refuse;

  always_comb begin
    isLoad  = 1'b0;
    isStore = 1'b0;
    isWord  = 1'b0;
    known   = 1'b1;
    case (opcode)
      OPC_LOAD_WORD:  begin isLoad  = 1'b1; isWord = 1'b1; end
      OPC_STORE_WORD: begin isStore = 1'b1; isWord = 1'b1; end
      OPC_LOAD_BYTE:  isLoad  = 1'b1;
      OPC_STORE_BYTE: isStore = 1'b1;
      default:        known   = 1'b0;
    endcase
  end

  assign aligned = (addrLow == '0);
  assign refuse  = reqValid && known && isWord && !aligned;

  always_comb begin
    strobe          = '0;
    strobe.addrErr  = refuse;
    strobe.wordSize = isWord;
    strobe.rdEn     = reqValid && known && isLoad  && !refuse;
    strobe.wrEn     = reqValid && known && isStore && !refuse;
  end
endmodule

// File: rtl/ls_lane_datapath.sv
module ls_lane_datapath
  import ls_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DATA_W-1:0]             baseReg,
  input  logic [OFF_W-1:0]              offset,
  input  logic [DATA_W-1:0]             storeData,
  input  lsStrobe_t                     strobe,
  input  logic [DATA_W-1:0]             memRdata,
  output logic [$clog2(DATA_W/8)-1:0]   effLow,
  output logic [DATA_W-$clog2(DATA_W/8)-1:0] memWordAddr,
  output logic [DATA_W/8-1:0]           memByteEn,
  output logic [DATA_W-1:0]             memWdata,
  output logic                          loadValid,
  output logic [DATA_W-1:0]             loadData
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  logic [DATA_W-1:0]    effAddr;
  logic [DATA_W-1:0]    offsetExt;
  logic                 pendValid;
  logic                 pendWord;
  logic [LANE_BITS-1:0] pendLow;
  logic [7:0]           pickedByte;

  assign offsetExt   = {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign effAddr     = baseReg + offsetExt;
  assign effLow      = effAddr[LANE_BITS-1:0];
  assign memWordAddr = effAddr[DATA_W-1:LANE_BITS];

  // big-endian lane steering: byte offset k lives in lane LANES-1-k
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic laneHit;
    assign laneHit = (effLow == LANE_BITS'(LANES - 1 - g));
    assign memByteEn[g] = strobe.wrEn && (strobe.wordSize || laneHit);
    assign memWdata[8*g +: 8] = strobe.wordSize ? storeData[8*g +: 8] : storeData[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendWord  <= 1'b0;
      pendLow   <= '0;
    end else begin
      pendValid <= strobe.rdEn;
      pendWord  <= strobe.wordSize;
      pendLow   <= effLow;
    end
  end

  always_comb begin
    pickedByte = '0;
    for (int k = 0; k < LANES; k++) begin
      if (pendLow == LANE_BITS'(k)) pickedByte = memRdata[8*(LANES-1-k) +: 8];
    end
  end

  assign loadValid = pendValid;
  assign loadData  = pendWord ? memRdata
                              : {{(DATA_W-8){pickedByte[7]}}, pickedByte};
endmodule

// File: rtl/ls_lane_unit.sv
module ls_lane_unit
  import ls_lane_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [5:0]  opcode,
  input  logic [31:0] baseReg,
  input  logic [15:0] offset,
  input  logic [31:0] storeData,
  output logic [29:0] memWordAddr,
  output logic [3:0]  memByteEn,
  output logic        memWrite,
  output logic        memRead,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic        loadValid,
  output logic [31:0] loadData,
  output logic        misaligned
);
  localparam int DATA_W    = 32;
  localparam int OFF_W     = 16;
  localparam int LANE_BITS = $clog2(DATA_W / 8);

  lsStrobe_t            strobe;
  logic [LANE_BITS-1:0] effLow;

  ls_lane_ctrl #(.LANE_BITS(LANE_BITS)) u_ctrl (
    .reqValid (reqValid),
    .opcode   (opcode),
    .addrLow  (effLow),
    .strobe   (strobe)
  );

  ls_lane_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .baseReg     (baseReg),
    .offset      (offset),
    .storeData   (storeData),
    .strobe      (strobe),
    .memRdata    (memRdata),
    .effLow      (effLow),
    .memWordAddr (memWordAddr),
    .memByteEn   (memByteEn),
    .memWdata    (memWdata),
    .loadValid   (loadValid),
    .loadData    (loadData)
  );

  assign memRead    = strobe.rdEn;
  assign memWrite   = strobe.wrEn;
  assign misaligned = strobe.addrErr;
endmodule

// File: rtl/ls_lane_unit_chk.sv
module ls_lane_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [5:0]  opcode,
  input logic [31:0] baseReg,
  input logic [15:0] offset,
  input logic [31:0] storeData,
  input logic [29:0] memWordAddr,
  input logic [3:0]  memByteEn,
  input logic        memWrite,
  input logic        memRead,
  input logic [31:0] memWdata,
  input logic        loadValid,
  input logic        misaligned
);
  logic [31:0] expAddr;
  assign expAddr = baseReg + 32'($signed(offset));

  assert_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRead || memWrite) |-> memWordAddr == expAddr[31:2]);

  assert_idle_opcode_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode != 6'd35 && opcode != 6'd43 && opcode != 6'd32 && opcode != 6'd40)
      |-> (!memRead && !memWrite && memByteEn == 4'h0 && !misaligned));

  assert_word_store_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode == 6'd43 && !misaligned)
      |-> (memWrite && memByteEn == 4'hF && memWdata == storeData));

  assert_byte_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode == 6'd40) |-> (memWrite && $countones(memByteEn) == 1));

  assert_read_return_R5: assert property (@(posedge clk) disable iff (!rstN)
    memRead |=> loadValid);

  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (!memRead && !memWrite && memByteEn == 4'h0));

  assert_no_load_after_refuse_R7: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |=> !loadValid);

  assert_byte_never_refused_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (opcode == 6'd32 || opcode == 6'd40)) |-> !misaligned);

  assert_valid_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(memRead));

  always @(posedge clk) begin
    if (!rstN) assert_reset_quiet_R9: assert (!loadValid);
  end
endmodule

bind ls_lane_unit ls_lane_unit_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .opcode      (opcode),
  .baseReg     (baseReg),
  .offset      (offset),
  .storeData   (storeData),
  .memWordAddr (memWordAddr),
  .memByteEn   (memByteEn),
  .memWrite    (memWrite),
  .memRead     (memRead),
  .memWdata    (memWdata),
  .loadValid   (loadValid),
  .misaligned  (misaligned)
);

// File: tb/ls_lane_unit_tb.sv
module ls_lane_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [5:0]  opcode;
  logic [31:0] baseReg;
  logic [15:0] offset;
  logic [31:0] storeData;
  logic [29:0] memWordAddr;
  logic [3:0]  memByteEn;
  logic        memWrite, memRead, loadValid, misaligned;
  logic [31:0] memWdata, memRdata, loadData;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  ls_lane_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode),
    .baseReg(baseReg), .offset(offset), .storeData(storeData),
    .memWordAddr(memWordAddr), .memByteEn(memByteEn), .memWrite(memWrite),
    .memRead(memRead), .memWdata(memWdata), .memRdata(memRdata),
    .loadValid(loadValid), .loadData(loadData), .misaligned(misaligned)
  );

  // small word memory, indexed by word address bits 3:0
  logic [31:0] mem [16];
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    memRdata = '0;
  end
  always @(posedge clk) begin
    if (memWrite)
      for (int b = 0; b < 4; b++)
        if (memByteEn[b]) mem[memWordAddr[3:0]][8*b +: 8] <= memWdata[8*b +: 8];
    if (memRead) memRdata <= mem[memWordAddr[3:0]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] sdata;
    logic [29:0] expAddr;
    logic [3:0]  expEn;
    logic [31:0] expWdata;
    logic        expMis;
    logic [31:0] expLoad;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{6'd43, 32'h00000100, 16'h0004, 32'h8899AABB, 30'h00000041, 4'hF, 32'h8899AABB, 1'b0, 32'h0},
    '{6'd40, 32'h00000108, 16'hFFFF, 32'h1234565A, 30'h00000041, 4'h1, 32'h5A5A5A5A, 1'b0, 32'h0},
    '{6'd40, 32'h00000104, 16'h0000, 32'h000000C3, 30'h00000041, 4'h8, 32'hC3C3C3C3, 1'b0, 32'h0},
    '{6'd35, 32'h000000FC, 16'h0008, 32'h0,        30'h00000041, 4'h0, 32'h0,        1'b0, 32'hC399AA5A},
    '{6'd32, 32'h00000200, 16'hFF04, 32'h0,        30'h00000041, 4'h0, 32'h0,        1'b0, 32'hFFFFFFC3},
    '{6'd32, 32'h00000106, 16'h0000, 32'h0,        30'h00000041, 4'h0, 32'h0,        1'b0, 32'hFFFFFFAA},
    '{6'd32, 32'h00000107, 16'h0000, 32'h0,        30'h00000041, 4'h0, 32'h0,        1'b0, 32'h0000005A},
    '{6'd32, 32'h00000105, 16'h0000, 32'h0,        30'h00000041, 4'h0, 32'h0,        1'b0, 32'hFFFFFF99},
    '{6'd43, 32'h00000104, 16'h0001, 32'hDEADBEEF, 30'h0,        4'h0, 32'h0,        1'b1, 32'h0},
    '{6'd35, 32'h00000100, 16'h0003, 32'h0,        30'h0,        4'h0, 32'h0,        1'b1, 32'h0},
    '{6'd35, 32'h00000104, 16'h0000, 32'h0,        30'h00000041, 4'h0, 32'h0,        1'b0, 32'hC399AA5A},
    '{6'd0,  32'h00000104, 16'h0000, 32'hFFFFFFFF, 30'h0,        4'h0, 32'h0,        1'b0, 32'h0},
    '{6'd43, 32'h00001000, 16'h8000, 32'h00000077, 30'h3FFFE400, 4'hF, 32'h00000077, 1'b0, 32'h0},
    '{6'd32, 32'hFFFF9003, 16'h0000, 32'h0,        30'h3FFFE400, 4'h0, 32'h0,        1'b0, 32'h00000077}
  };

  task automatic drive(input logic v, input logic [5:0] op, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] s);
    reqValid = v; opcode = op; baseReg = b; offset = o; storeData = s;
  endtask

  initial begin
    rstN = 1'b0;
    drive(1'b0, 6'd0, '0, '0, '0);
    repeat (2) @(negedge clk);
    #2;
    check("R9 reset loadValid", {31'b0, loadValid}, 32'h0);
    check("R9 reset strobes", {30'b0, memRead, memWrite}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // table walk: request cycle, then result cycle
    for (int i = 0; i < NVEC; i++) begin
      automatic vec_t v = VECS[i];
      automatic bit known  = (v.op == 6'd35 || v.op == 6'd43 || v.op == 6'd32 || v.op == 6'd40);
      automatic bit isWord = (v.op == 6'd35 || v.op == 6'd43);
      automatic bit isLd   = known && (v.op == 6'd35 || v.op == 6'd32) && !v.expMis;
      automatic bit isSt   = known && (v.op == 6'd43 || v.op == 6'd40) && !v.expMis;
      @(negedge clk);
      drive(1'b1, v.op, v.base, v.off, v.sdata);
      #2;
      check(known ? (isWord ? "R7 misaligned flag" : "R8 byte never flagged") : "R2 unknown op flag",
            {31'b0, misaligned}, {31'b0, v.expMis});
      check(v.expMis ? "R7 strobes refused" : (known ? "R2 strobes" : "R2 unknown op strobes"),
            {30'b0, memRead, memWrite}, {30'b0, isLd, isSt});
      check(isWord ? "R3 byte enables" : "R4 byte enables", {28'b0, memByteEn}, {28'b0, v.expEn});
      if (isLd || isSt) check("R1 word address", {2'b0, memWordAddr}, {2'b0, v.expAddr});
      if (isSt) check(isWord ? "R3 write data" : "R4 write data", memWdata, v.expWdata);
      @(negedge clk);
      drive(1'b0, 6'd0, '0, '0, '0);
      #2;
      check(v.expMis ? "R7 no load result" : "R5 loadValid", {31'b0, loadValid}, {31'b0, isLd});
      if (isLd) check(isWord ? "R5 load word" : "R6 load byte", loadData, v.expLoad);
    end

    // R10: load result returns in the same cycle a byte store is issued
    @(negedge clk);
    drive(1'b1, 6'd35, 32'h00000104, 16'h0000, 32'h0);
    @(negedge clk);
    drive(1'b1, 6'd40, 32'h00000100, 16'h0000, 32'h00000081);
    #2;
    check("R10 overlap loadValid", {31'b0, loadValid}, 32'h1);
    check("R10 overlap load word", loadData, 32'hC399AA5A);
    check("R10 overlap store enables", {28'b0, memByteEn}, 32'h8);
    check("R10 overlap store data", memWdata, 32'h81818181);
    check("R10 overlap store address", {2'b0, memWordAddr}, 32'h40);
    @(negedge clk);
    drive(1'b1, 6'd32, 32'h00000100, 16'h0000, 32'h0);
    #2;
    check("R9 no result after store", {31'b0, loadValid}, 32'h0);
    @(negedge clk);
    drive(1'b0, 6'd0, '0, '0, '0);
    #2;
    check("R6 reload stored byte", loadData, 32'hFFFFFF81);

    // R9: reset during a pending load drops the result
    @(negedge clk);
    drive(1'b1, 6'd35, 32'h00000104, 16'h0000, 32'h0);
    @(negedge clk);
    rstN = 1'b0;
    drive(1'b0, 6'd0, '0, '0, '0);
    #2;
    check("R9 reset clears pending load", {31'b0, loadValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule